// File: doc/BRIEF.md
# Periodic Compare Timer

This block is a 64-bit time-base counter that moves forward by a small programmable step on every clock while it is enabled. A set of 64-bit compare channels watches the counter. When an enabled channel's value equals the count, the channel gives a one-clock event pulse and sets a sticky status bit. Software clears a status bit by writing a 1 to it.

Compare channel 0 can also serve as a period register. When its reset option is on, the counter returns to zero on the clock after a channel 0 match. The counter then repeats a fixed cycle, and the other channels mark phases inside that cycle. The pulses and status bits feed interrupt logic or downstream pulse shapers.

All setup goes through a plain word-wide register port. Writes are single-cycle strobes and reads are combinational. The counter and each compare value are reached as two 32-bit words.

Top module: `ptimer`

## Requirements
- R1: After reset the counter, all configuration, all status bits and all event outputs are zero.
- R2: The global configuration word is at offset 0x00. Bit 0 enables counting, and bits 7:4 hold the step that is added to the counter on every clock while counting is enabled.
- R3: While counting is disabled the counter holds its value, and no compare events or status bits are produced, even when a compare value equals the held count.
- R4: The counter's low word is at 0x10 and its high word is at 0x14. A write to either word is visible on the next clock and overrides that clock's step. Both words read back the live count.
- R5: Compare channel n keeps its low word at 0x20+8n and its high word at 0x24+8n, and both read back. A match needs all 64 bits to be equal.
- R6: Compare configuration is at 0x04, and its bit n+1 enables channel n. A match on an enabled channel gives a single-clock pulse on cmp_evt[n] and sets cmp_stat[n]. Both appear on the clock after the count equals the compare value.
- R7: A channel whose enable bit is clear never pulses and never sets its status bit.
- R8: When bit 0 of the compare configuration is set, the counter loads zero on the clock after a channel 0 match. The cycle length is then cmp0/step+1 clocks. When bit 0 is clear, the counter counts through the channel 0 value.
- R9: The status word at 0x08 holds sticky bit n for channel n. Writing 1 to a bit clears it and writing 0 leaves it unchanged, so writing 0x13 clears channels 0, 1 and 4 only.
- R10: If a match sets a status bit on the same clock that software clears it, the bit ends up set.
- R11: The counter wraps from all-ones to zero modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cmp_evt | output | NCH | One-clock compare event per channel |
| cmp_stat | output | NCH | Sticky compare status per channel |

## Verification
The compare function is exercised with a plain free run against one channel and with a 64-bit value whose low word alone matches, which separates a full-width compare from a truncated one. It is also run with channel 0 wrapping at unit step and again at a step of three, which distinguishes a wrap on the match clock from a wrap one clock late and gives periods of 10 and 4 clocks. A third run has the reset option off, to show that the counter passes through the channel 0 value. Status handling is checked with four channels set at once, cleared with a zero write and then with 0x13, and with a clear that lands on the match clock.

// File: rtl/ptimer.sv
module ptimer #(
  parameter int NCH = 5,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [NCH-1:0] cmp_evt,
  output logic [NCH-1:0] cmp_stat
);
  localparam logic [AW-1:0] A_GCFG = AW'(0);
  localparam logic [AW-1:0] A_CCFG = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(8);
  localparam logic [AW-1:0] A_CNTL = AW'(16);
  localparam logic [AW-1:0] A_CNTH = AW'(20);
  localparam int            A_CMP  = 32;

  logic           run_q;
  logic [3:0]     inc_q;
  logic           rst_en_q;
  logic [NCH-1:0] ch_en_q;
  logic [63:0]    count_q;
  logic [63:0]    cmp_q [NCH];
  logic [NCH-1:0] match;

  wire gcfg_wr  = bus_wr && bus_addr == A_GCFG;
  wire ccfg_wr  = bus_wr && bus_addr == A_CCFG;
  wire stat_wr  = bus_wr && bus_addr == A_STAT;
  wire cntl_wr  = bus_wr && bus_addr == A_CNTL;
  wire cnth_wr  = bus_wr && bus_addr == A_CNTH;
  wire cnt_wr   = cntl_wr || cnth_wr;
  wire wrap     = rst_en_q && match[0];

  for (genvar n = 0; n < NCH; n++) begin : g_match
    assign match[n] = run_q && ch_en_q[n] && (count_q == cmp_q[n]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      inc_q    <= '0;
      rst_en_q <= 1'b0;
      ch_en_q  <= '0;
    end else begin
      if (gcfg_wr) begin
        run_q <= bus_wdata[0];
        inc_q <= bus_wdata[7:4];
      end
      if (ccfg_wr) begin
        rst_en_q <= bus_wdata[0];
        ch_en_q  <= bus_wdata[NCH:1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else if (cnt_wr)
      count_q <= {cnth_wr ? bus_wdata : count_q[63:32],
                  cntl_wr ? bus_wdata : count_q[31:0]};
    else if (run_q)
      count_q <= wrap ? '0 : count_q + 64'(inc_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) cmp_q[n] <= '0;
    end else if (bus_wr) begin
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == AW'(A_CMP + 8*n))     cmp_q[n][31:0]  <= bus_wdata;
        if (bus_addr == AW'(A_CMP + 8*n + 4)) cmp_q[n][63:32] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_evt  <= '0;
      cmp_stat <= '0;
    end else begin
      cmp_evt  <= match;
      cmp_stat <= (cmp_stat & ~(stat_wr ? bus_wdata[NCH-1:0] : '0)) | match;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GCFG: bus_rdata = {24'b0, inc_q, 3'b0, run_q};
      A_CCFG: bus_rdata = 32'({ch_en_q, rst_en_q});
      A_STAT: bus_rdata = 32'(cmp_stat);
      A_CNTL: bus_rdata = count_q[31:0];
      A_CNTH: bus_rdata = count_q[63:32];
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(A_CMP + 8*n))     bus_rdata = cmp_q[n][31:0];
      if (bus_addr == AW'(A_CMP + 8*n + 4)) bus_rdata = cmp_q[n][63:32];
    end
  end
endmodule

// File: rtl/ptimer_chk.sv
module ptimer_chk #(
  parameter int NCH = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic [3:0]     inc,
  input logic           rst_en,
  input logic           ch0_en,
  input logic [63:0]    cmp0,
  input logic [63:0]    count,
  input logic           cnt_wr,
  input logic           stat_wr,
  input logic [NCH-1:0] evt,
  input logic [NCH-1:0] stat
);
  wire wrap_due = run && rst_en && ch0_en && (count == cmp0);

  AST_EVT_HAS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~stat) == '0);  // R6
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));  // R3
  AST_NO_EVT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> evt == '0);  // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_due && !cnt_wr) |=> count == 64'd0);  // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr && !wrap_due) |=> count == $past(count) + 64'($past(inc)));  // R2
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (stat & $past(stat)) == $past(stat));  // R9
endmodule

bind ptimer ptimer_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run_q), .inc(inc_q), .rst_en(rst_en_q),
  .ch0_en(ch_en_q[0]), .cmp0(cmp_q[0]), .count(count_q), .cnt_wr(cnt_wr),
  .stat_wr(stat_wr), .evt(cmp_evt), .stat(cmp_stat)
);

// File: tb/ptimer_tb_top.sv
module ptimer_tb_top;
  localparam int NCH = 5;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] cmp_evt, cmp_stat;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ptimer #(.NCH(NCH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_evt(cmp_evt), .cmp_stat(cmp_stat)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic set_count(input logic [63:0] v);
    wr(8'h10, v[31:0]); wr(8'h14, v[63:32]);
  endtask

  task automatic set_cmp(input int n, input logic [63:0] v);
    wr(AW'(32 + 8*n), v[31:0]); wr(AW'(36 + 8*n), v[63:32]);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1 gcfg", d, 0);
    rd(8'h04, d); check("R1 ccfg", d, 0);
    rd(8'h08, d); check("R1 stat", d, 0);
    rd(8'h10, d); check("R1 count lo", d, 0);
    rd(8'h14, d); check("R1 count hi", d, 0);
    check("R1 evt", cmp_evt, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(8'h00, 32'h30); set_count(0);
    wr(8'h00, 32'h31);
    rd(8'h00, d); check("R2 gcfg readback", d, 32'h31);
    rd(8'h10, d); check("R2 count at enable", d, 0);
    repeat (5) @(negedge clk);
    rd(8'h10, d); check("R2 count after 5 steps of 3", d, 15);
  endtask

  task automatic t_hold;
    logic [31:0] x, d;
    wr(8'h00, 32'h30);
    rd(8'h10, x);
    set_cmp(1, {32'h0, x});
    wr(8'h04, 32'h04); wr(8'h08, 32'h1f);
    repeat (5) begin
      @(negedge clk);
      check("R3 no event while off", cmp_evt, 0);
    end
    rd(8'h10, d); check("R3 count held", d, x);
    rd(8'h08, d); check("R3 no status while off", d, 0);
  endtask

  task automatic t_cntwr;
    logic [31:0] d;
    wr(8'h04, 0);
    set_count(64'h01234567_89abcdef);
    rd(8'h10, d); check("R4 lo readback", d, 32'h89abcdef);
    rd(8'h14, d); check("R4 hi readback", d, 32'h01234567);
    wr(8'h00, 32'h11);
    wr(8'h10, 100);
    rd(8'h10, d); check("R4 write overrides step", d, 100);
    @(negedge clk);
    rd(8'h10, d); check("R4 counting resumes", d, 101);
    wr(8'h00, 32'h10);
  endtask

  task automatic t_cmp;
    logic [31:0] prev, cur, d;
    wr(8'h00, 32'h10); set_count(0);
    set_cmp(1, 20); set_cmp(2, 7); set_cmp(3, {32'h1, 32'd5});
    rd(8'h28, d); check("R5 cmp1 lo readback", d, 20);
    rd(8'h3c, d); check("R5 cmp3 hi readback", d, 1);
    wr(8'h04, 32'h14); wr(8'h08, 32'h1f);
    wr(8'h00, 32'h11);
    rd(8'h10, prev);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      rd(8'h10, cur);
      check("R6 ch1 pulse", cmp_evt[1], prev == 20);
      check("R7 ch2 disabled", cmp_evt[2], 0);
      check("R5 ch3 needs high word", cmp_evt[3], 0);
      prev = cur;
    end
    wr(8'h00, 32'h10);
    rd(8'h08, d); check("R6 R7 status", d, 32'h02);
  endtask

  task automatic run_period(input logic [3:0] step, input int cmpv, input int exp_per);
    logic [31:0] prev, cur;
    int last = -1;
    wr(8'h00, 32'h10); set_count(0);
    set_cmp(0, cmpv);
    wr(8'h04, 32'h03); wr(8'h08, 32'h1f);
    wr(8'h00, {24'h0, step, 4'h1});
    rd(8'h10, prev);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      rd(8'h10, cur);
      if (prev == cmpv) check("R8 wrap to zero", cur, 0);
      else check("R8 step", cur, prev + step);
      check("R8 ch0 pulse", cmp_evt[0], prev == cmpv);
      if (cmp_evt[0]) begin
        if (last >= 0) check("R8 period", i - last, exp_per);
        last = i;
      end
      prev = cur;
    end
    wr(8'h00, 32'h10);
  endtask

  task automatic t_period;
    logic [31:0] d;
    run_period(4'd1, 9, 10);
    run_period(4'd3, 9, 4);
    set_count(0); wr(8'h04, 32'h02);
    wr(8'h00, 32'h11);
    repeat (12) @(negedge clk);
    rd(8'h10, d); check("R8 no reset passes cmp0", d, 12);
    wr(8'h00, 32'h10);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    set_count(0);
    set_cmp(0, 2); set_cmp(1, 2); set_cmp(2, 2); set_cmp(4, 2);
    wr(8'h04, 32'h2e); wr(8'h08, 32'h1f);
    wr(8'h00, 32'h11);
    repeat (6) @(negedge clk);
    wr(8'h00, 32'h10);
    rd(8'h08, d); check("R9 all set", d, 32'h17);
    wr(8'h08, 0);
    rd(8'h08, d); check("R9 zero write keeps", d, 32'h17);
    wr(8'h08, 32'h13);
    rd(8'h08, d); check("R9 0x13 clears 0,1,4", d, 32'h04);
    wr(8'h08, 32'h04);
    rd(8'h08, d); check("R9 last bit cleared", d, 0);
  endtask

  task automatic t_setwins;
    logic [31:0] d;
    wr(8'h04, 32'h04); set_cmp(1, 5); set_count(5); wr(8'h08, 32'h1f);
    wr(8'h00, 32'h11);
    wr(8'h08, 32'h02);
    check("R10 event on clear clock", cmp_evt[1], 1);
    rd(8'h08, d); check("R10 set beats clear", d[1], 1);
    wr(8'h08, 32'h02);
    rd(8'h08, d); check("R10 later clear works", d[1], 0);
    wr(8'h00, 32'h10);
  endtask

  task automatic t_wrap64;
    logic [31:0] d;
    wr(8'h04, 0);
    set_count(64'hffffffff_fffffffe);
    wr(8'h00, 32'h11);
    rd(8'h10, d); check("R11 lo start", d, 32'hfffffffe);
    @(negedge clk);
    rd(8'h10, d); check("R11 lo max", d, 32'hffffffff);
    @(negedge clk);
    rd(8'h10, d); check("R11 lo wrapped", d, 0);
    rd(8'h14, d); check("R11 hi wrapped", d, 0);
    wr(8'h00, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_count;
    t_hold;
    t_cntwr;
    t_cmp;
    t_period;
    t_w1c;
    t_setwins;
    t_wrap64;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule